// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

On-chip interrupt sources present events to this block one per cycle. Each event is packed into a 128-bit vector and written into a circular buffer in memory through a single-cycle write port that may be stalled. The block owns a byte-offset write pointer. The host owns a read pointer, which it sets through a small register interface. While unread vectors remain, the block holds an interrupt line high.

The ring size is programmed as log2 of the size in 32-bit words. Vectors advance the write pointer by 16 bytes. When the ring is full, a new vector overwrites the oldest entry. If overflow detection is enabled, a sticky overflow flag is also raised in the reported write pointer. The host then resumes reading at wptr+16, pulses the clear bit high and then low, and only after that can a new overflow be flagged. When writeback is enabled, each pointer update is mirrored to a separate writeback address.

A four-entry input FIFO absorbs stalls on the memory port. An event is lost only when that FIFO is full and the port is stalled, and a sticky drop flag records the loss.

Top module: `ivr_writer`

## Requirements
- R1: Each vector carries the source id in bits [7:0], the 28-bit source data in [59:32], the ring id in [71:64], the VMID in [79:72] and the PASID in [95:80]. Every other bit is zero.
- R2: A vector is written to address {base register, 8'h00} + wptr. mem_we_o is high exactly when the block is enabled, the FIFO holds a vector and mem_stall_i is low. Each write advances wptr by 16, masked to the ring: mask = (4 << size) - 1 with bits [3:0] cleared, where size is control bits [5:1].
- R3: irq_o is high exactly when the block is enabled and either rptr differs from wptr or the overflow flag is set. A host write to the rptr register (address 2, bits [15:0], masked like wptr) takes effect on the next cycle.
- R4: With overflow-enable (control bit 6) set, writing a vector when ((wptr+16) & mask) equals rptr sets the overflow flag. The flag reads back in bit 31 of the wptr register (address 3), and the pointer bits [15:0] stay masked.
- R5: While overflow-clear (control bit 7) is 1, the overflow flag is cleared and cannot be set. A new overflow is flagged only after the bit has been written back to 0.
- R6: The block is enabled only when both ring-enable (control bit 0) and global interrupt-enable (control bit 9) are 1. While it is not enabled, rptr, wptr, the overflow flag, the drop flag and the FIFO are cleared.
- R7: With writeback-enable (control bit 8) set, the cycle after each wptr advance drives wb_we_o, together with wb_data_o = {overflow flag, 15'b0, wptr}, to wb_addr_o = {address 5 bits [7:0], address 4}.
- R8: Status bit 0 (address 6) is high while the input FIFO holds vectors not yet written.
- R9: The input FIFO holds 4 events. An event is dropped only when the FIFO is full and the port is stalled, and the drop sets the sticky status bit 1.
- R10: Events presented while the block is not enabled are ignored. They produce no memory write and leave nothing in the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_valid_i | input | 1 | Event present this cycle |
| evt_src_i | input | 8 | Source id |
| evt_data_i | input | 28 | Source data |
| evt_ring_i | input | 8 | Ring id |
| evt_vmid_i | input | 8 | VMID |
| evt_pasid_i | input | 16 | PASID |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mem_we_o | output | 1 | Vector write strobe |
| mem_addr_o | output | 40 | Vector byte address |
| mem_wdata_o | output | 128 | Vector data |
| mem_stall_i | input | 1 | Memory port cannot take a write this cycle |
| wb_we_o | output | 1 | Writeback write strobe |
| wb_addr_o | output | 40 | Writeback address |
| wb_data_o | output | 32 | Writeback pointer value |
| irq_o | output | 1 | Unread vectors pending |

## Verification
Single events with widely varied field values separate the field placement from the addressing. Back-to-back bursts with the port stalled tell FIFO ordering and capacity apart from the drop rule. Filling a small ring without moving rptr tells the overwrite and flag path apart from ordinary wrap. Holding the clear bit high during further traffic separates the set-then-clear rule from a simple one-shot clear. Runs with only one of the two enable bits set, and a disable in mid-traffic, check that pointers are cleared and that ignored events leave no trace. A second ring size checks the mask derivation.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  typedef logic [127:0] vec_t;

  typedef struct packed {
    logic [7:0]  src;
    logic [27:0] data;
    logic [7:0]  ring;
    logic [7:0]  vmid;
    logic [15:0] pasid;
  } evt_t;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_BASE  = 3'd1;
  localparam logic [2:0] RA_RPTR  = 3'd2;
  localparam logic [2:0] RA_WPTR  = 3'd3;
  localparam logic [2:0] RA_WB_LO = 3'd4;
  localparam logic [2:0] RA_WB_HI = 3'd5;
  localparam logic [2:0] RA_STAT  = 3'd6;

  localparam int CTRL_W     = 10;
  localparam int CB_EN      = 0;
  localparam int CB_SIZE    = 1;
  localparam int SIZE_W     = 5;
  localparam int CB_OVF_EN  = 6;
  localparam int CB_OVF_CLR = 7;
  localparam int CB_WB_EN   = 8;
  localparam int CB_GIE     = 9;

  function automatic vec_t pack_vec(evt_t e);
    return {32'h0, e.pasid, e.vmid, e.ring, 4'h0, e.data, 24'h0, e.src};
  endfunction
endpackage

// File: rtl/ivr_fifo.sv
module ivr_fifo
  import ivr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic push_i,
  input  vec_t din_i,
  input  logic pop_i,
  output vec_t head_o,
  output logic empty_o,
  output logic full_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CMAX = CNT_W'(DEPTH);

  vec_t             store_q [DEPTH];
  logic [IDX_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CMAX);
  assign head_o  = store_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) store_q[wr_q] <= din_i;
  end

  p_no_overrun_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !flush_i) |-> (!full_o || pop_i));
  p_no_underrun_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter int BASE_W = 32,
  parameter int PTR_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [2:0]          addr_i,
  input  logic [31:0]         wdata_i,
  input  logic [PTR_W-1:0]    rptr_i,
  input  logic [PTR_W-1:0]    wptr_i,
  input  logic                ovf_i,
  input  logic                busy_i,
  input  logic                drop_i,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic [BASE_W-1:0]   base_o,
  output logic [39:0]         wb_addr_o,
  output logic                rptr_we_o,
  output logic [31:0]         rdata_o
);
  localparam int PAD = 31 - PTR_W;

  logic [31:0] wb_lo_q;
  logic [7:0]  wb_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      base_o  <= '0;
      wb_lo_q <= '0;
      wb_hi_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        RA_CTRL:  ctrl_o  <= wdata_i[CTRL_W-1:0];
        RA_BASE:  base_o  <= wdata_i[BASE_W-1:0];
        RA_WB_LO: wb_lo_q <= wdata_i;
        RA_WB_HI: wb_hi_q <= wdata_i[7:0];
        default: ;
      endcase
    end
  end

  assign rptr_we_o = we_i && (addr_i == RA_RPTR);
  assign wb_addr_o = {wb_hi_q, wb_lo_q};

  always_comb begin
    case (addr_i)
      RA_CTRL:  rdata_o = 32'(ctrl_o);
      RA_BASE:  rdata_o = 32'(base_o);
      RA_RPTR:  rdata_o = {1'b0, {PAD{1'b0}}, rptr_i};
      RA_WPTR:  rdata_o = {ovf_i, {PAD{1'b0}}, wptr_i};
      RA_WB_LO: rdata_o = wb_lo_q;
      RA_WB_HI: rdata_o = {24'h0, wb_hi_q};
      RA_STAT:  rdata_o = {30'h0, drop_i, busy_i};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ivr_ptr.sv
module ivr_ptr
  import ivr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              ovf_en_i,
  input  logic              ovf_clr_i,
  input  logic              wb_en_i,
  input  logic              adv_i,
  input  logic              drop_set_i,
  input  logic              rptr_we_i,
  input  logic [PTR_W-1:0]  rptr_wdata_i,
  output logic [PTR_W-1:0]  wptr_o,
  output logic [PTR_W-1:0]  rptr_o,
  output logic              ovf_o,
  output logic              drop_o,
  output logic              wb_we_o,
  output logic [31:0]       wb_data_o
);
  localparam int PAD = 31 - PTR_W;
  localparam logic [PTR_W-1:0] STEP = PTR_W'(16);

  logic [PTR_W-1:0] mask, wptr_nxt;
  logic             full, ovf_nxt;

  // ring bytes = 4 << size; entries are 16-byte aligned
  always_comb begin
    for (int i = 0; i < PTR_W; i++) mask[i] = (i >= 4) && (i < int'(size_i) + 2);
  end

  assign wptr_nxt = (wptr_o + STEP) & mask;
  assign full     = (wptr_nxt == rptr_o);
  assign ovf_nxt  = ovf_clr_i ? 1'b0 : (ovf_o || (adv_i && full && ovf_en_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_o    <= '0;
      rptr_o    <= '0;
      ovf_o     <= 1'b0;
      drop_o    <= 1'b0;
      wb_we_o   <= 1'b0;
      wb_data_o <= '0;
    end else if (!en_i) begin
      wptr_o    <= '0;
      rptr_o    <= '0;
      ovf_o     <= 1'b0;
      drop_o    <= 1'b0;
      wb_we_o   <= 1'b0;
      wb_data_o <= '0;
    end else begin
      if (adv_i) begin
        wptr_o    <= wptr_nxt;
        wb_data_o <= {ovf_nxt, {PAD{1'b0}}, wptr_nxt};
      end
      ovf_o   <= ovf_nxt;
      wb_we_o <= adv_i && wb_en_i;
      if (rptr_we_i)  rptr_o <= rptr_wdata_i & mask;
      if (drop_set_i) drop_o <= 1'b1;
    end
  end

  p_ptr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i) |=> (wptr_o == (($past(wptr_o) + STEP) & $past(mask))));
  p_ptr_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wptr_o[3:0] == 4'h0) && (rptr_o[3:0] == 4'h0));
  p_dis_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (wptr_o == '0 && rptr_o == '0 && !ovf_o && !drop_o));
  p_ovf_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ovf_clr_i) |=> !ovf_o);
  p_ovf_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i && ovf_en_i && !ovf_clr_i && full) |=> ovf_o);
  p_wb_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_we_o |-> ($past(adv_i) && $past(wb_en_i)));
endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
  import ivr_pkg::*;
#(
  parameter int PTR_W      = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int ADDR_W     = 40
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                evt_valid_i,
  input  logic [7:0]          evt_src_i,
  input  logic [27:0]         evt_data_i,
  input  logic [7:0]          evt_ring_i,
  input  logic [7:0]          evt_vmid_i,
  input  logic [15:0]         evt_pasid_i,
  input  logic                reg_we_i,
  input  logic [2:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [127:0]        mem_wdata_o,
  input  logic                mem_stall_i,
  output logic                wb_we_o,
  output logic [39:0]         wb_addr_o,
  output logic [31:0]         wb_data_o,
  output logic                irq_o
);
  localparam int BASE_W = ADDR_W - 8;

  logic [CTRL_W-1:0] ctrl;
  logic [BASE_W-1:0] base;
  logic              rptr_we, en, empty, full, push, pop, drop_set, ovf, drop;
  logic [PTR_W-1:0]  wptr, rptr;
  evt_t              evt;
  vec_t              head;

  assign en  = ctrl[CB_EN] && ctrl[CB_GIE];
  assign evt = '{src: evt_src_i, data: evt_data_i, ring: evt_ring_i,
                 vmid: evt_vmid_i, pasid: evt_pasid_i};

  assign pop      = en && !empty && !mem_stall_i;
  assign push     = en && evt_valid_i && (!full || pop);
  assign drop_set = en && evt_valid_i && full && !pop;

  ivr_regs #(.BASE_W(BASE_W), .PTR_W(PTR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rptr_i    (rptr),
    .wptr_i    (wptr),
    .ovf_i     (ovf),
    .busy_i    (!empty),
    .drop_i    (drop),
    .ctrl_o    (ctrl),
    .base_o    (base),
    .wb_addr_o (wb_addr_o),
    .rptr_we_o (rptr_we),
    .rdata_o   (reg_rdata_o)
  );

  ivr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i (!en),
    .push_i  (push),
    .din_i   (pack_vec(evt)),
    .pop_i   (pop),
    .head_o  (head),
    .empty_o (empty),
    .full_o  (full)
  );

  ivr_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i, .rst_ni,
    .en_i         (en),
    .size_i       (ctrl[CB_SIZE +: SIZE_W]),
    .ovf_en_i     (ctrl[CB_OVF_EN]),
    .ovf_clr_i    (ctrl[CB_OVF_CLR]),
    .wb_en_i      (ctrl[CB_WB_EN]),
    .adv_i        (pop),
    .drop_set_i   (drop_set),
    .rptr_we_i    (rptr_we),
    .rptr_wdata_i (reg_wdata_i[PTR_W-1:0]),
    .wptr_o       (wptr),
    .rptr_o       (rptr),
    .ovf_o        (ovf),
    .drop_o       (drop),
    .wb_we_o      (wb_we_o),
    .wb_data_o    (wb_data_o)
  );

  assign mem_we_o    = pop;
  assign mem_addr_o  = {base, 8'h00} + ADDR_W'(wptr);
  assign mem_wdata_o = head;
  assign irq_o       = en && ((rptr != wptr) || ovf);

  p_irq_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> en);
  p_stall_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_stall_i |-> !mem_we_o);
  p_dis_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !mem_we_o);
endmodule

// File: tb/ivr_writer_tb.sv
module ivr_writer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         evt_valid_i = 1'b0;
  logic [7:0]   evt_src_i = '0;
  logic [27:0]  evt_data_i = '0;
  logic [7:0]   evt_ring_i = '0;
  logic [7:0]   evt_vmid_i = '0;
  logic [15:0]  evt_pasid_i = '0;
  logic         reg_we_i = 1'b0;
  logic [2:0]   reg_addr_i = '0;
  logic [31:0]  reg_wdata_i = '0;
  logic [31:0]  reg_rdata_o;
  logic         mem_we_o;
  logic [39:0]  mem_addr_o;
  logic [127:0] mem_wdata_o;
  logic         mem_stall_i = 1'b0;
  logic         wb_we_o;
  logic [39:0]  wb_addr_o;
  logic [31:0]  wb_data_o;
  logic         irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivr_writer dut_i (
    .clk_i(clk), .rst_ni, .evt_valid_i, .evt_src_i, .evt_data_i, .evt_ring_i,
    .evt_vmid_i, .evt_pasid_i, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_stall_i, .wb_we_o, .wb_addr_o,
    .wb_data_o, .irq_o
  );

  localparam int EN = 1, OVFEN = 64, OVFCLR = 128, WBEN = 256, GIE = 512;

  int checks = 0, errors = 0;
  bit done = 0;
  int rot = 0;

  // reference model state
  logic [9:0]   m_ctrl = '0;
  logic [31:0]  m_base = '0, m_wblo = '0;
  logic [7:0]   m_wbhi = '0;
  logic [15:0]  m_rptr = '0, m_wptr = '0;
  bit           m_ovf = 0, m_drop = 0, m_wbwe = 0;
  logic [31:0]  m_wbdata = '0;
  logic [127:0] q[$];

  function automatic bit m_en();
    return m_ctrl[0] && m_ctrl[9];
  endfunction

  function automatic logic [15:0] m_mask();
    int sz = int'(m_ctrl[5:1]);
    longint bytes;
    if (sz + 2 >= 16) return 16'hFFF0;
    bytes = longint'(1) << (sz + 2);
    return 16'(bytes - 1) & 16'hFFF0;
  endfunction

  function automatic logic [127:0] m_vec();
    return {32'd0, evt_pasid_i, evt_vmid_i, evt_ring_i, 4'd0, evt_data_i, 24'd0, evt_src_i};
  endfunction

  function automatic logic [31:0] m_rdata(logic [2:0] a);
    case (a)
      3'd0: return {22'd0, m_ctrl};
      3'd1: return m_base;
      3'd2: return {16'd0, m_rptr};
      3'd3: return {m_ovf, 15'd0, m_wptr};
      3'd4: return m_wblo;
      3'd5: return {24'd0, m_wbhi};
      3'd6: return {30'd0, m_drop, q.size() != 0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit we_exp;
    string rtag;
    we_exp = m_en() && q.size() != 0 && !mem_stall_i;
    chk("R2 R10 mem_we", mem_we_o, we_exp);
    if (we_exp) begin
      chk("R2 mem_addr", mem_addr_o, {m_base, 8'h00} + 40'(m_wptr));
      chk("R1 mem_wdata", mem_wdata_o, q[0]);
    end
    chk("R3 irq", irq_o, m_en() && (m_rptr != m_wptr || m_ovf));
    chk("R7 wb_we", wb_we_o, m_wbwe);
    if (m_wbwe) begin
      chk("R7 wb_data", wb_data_o, m_wbdata);
      chk("R7 wb_addr", wb_addr_o, {m_wbhi, m_wblo});
    end
    case (reg_addr_i)
      3'd0: rtag = "R6 ctrl";
      3'd1: rtag = "R2 base";
      3'd2: rtag = "R3 rptr";
      3'd3: rtag = "R4 R5 wptr";
      3'd6: rtag = "R8 R9 status";
      default: rtag = "R7 regs";
    endcase
    chk(rtag, reg_rdata_o, m_rdata(reg_addr_i));
  endtask

  task automatic model_step();
    bit en, pop, full, clr;
    logic [15:0] mask, nw;
    en = m_en();
    mask = m_mask();
    clr = m_ctrl[7];
    if (!en) begin
      m_rptr = 0; m_wptr = 0; m_ovf = 0; m_drop = 0; m_wbwe = 0; m_wbdata = 0;
      q.delete();
    end else begin
      pop = q.size() != 0 && !mem_stall_i;
      nw = (m_wptr + 16'd16) & mask;
      full = (nw == m_rptr);
      if (clr) m_ovf = 0;
      else if (pop && full && m_ctrl[6]) m_ovf = 1;
      m_wbwe = pop && m_ctrl[8];
      if (pop) begin
        m_wptr = nw;
        m_wbdata = {m_ovf, 15'd0, nw};
        void'(q.pop_front());
      end
      if (evt_valid_i) begin
        if (q.size() < 4) q.push_back(m_vec());
        else m_drop = 1;
      end
      if (reg_we_i && reg_addr_i == 3'd2) m_rptr = reg_wdata_i[15:0] & mask;
    end
    if (reg_we_i) begin
      case (reg_addr_i)
        3'd0: m_ctrl = reg_wdata_i[9:0];
        3'd1: m_base = reg_wdata_i;
        3'd4: m_wblo = reg_wdata_i;
        3'd5: m_wbhi = reg_wdata_i[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic tick();
    if (!reg_we_i) begin
      reg_addr_i = 3'(rot);
      rot++;
    end
    #1;
    compare();
    model_step();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    tick();
    reg_we_i = 0;
  endtask

  task automatic evt(int k);
    evt_valid_i = 1;
    evt_src_i   = 8'(k * 37 + 5);
    evt_data_i  = 28'(k * 32'h0123_4567 + 28'hFFF_0000);
    evt_ring_i  = 8'(k * 11);
    evt_vmid_i  = 8'(255 - k);
    evt_pasid_i = 16'(k * 16'h1357 + 16'h8001);
    tick();
    evt_valid_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    idle(8);                                   // R6 reset state
    // R10: ring enable without global enable ignores events
    reg_wr(3'd0, EN | (4 << 1));
    evt(1); evt(2); idle(3);
    reg_wr(3'd0, GIE | (4 << 1));
    evt(3); idle(2);
    // program and enable, 4-entry ring
    reg_wr(3'd1, 32'h1234_5600);
    reg_wr(3'd4, 32'hA000_0040);
    reg_wr(3'd5, 32'h0000_013C);
    reg_wr(3'd0, EN | GIE | (4 << 1) | OVFEN | WBEN);
    evt(4); evt(5); evt(6); idle(3);           // R1 R2 R7
    reg_wr(3'd2, 32'd48);                      // R3 catch up
    idle(2);
    // R9: stalled burst of six
    mem_stall_i = 1;
    for (int k = 10; k < 16; k++) evt(k);
    idle(2);
    mem_stall_i = 0;
    idle(6);                                   // R4 overflow here
    reg_wr(3'd0, EN | GIE | (4 << 1) | OVFEN | WBEN | OVFCLR);  // R5
    for (int k = 20; k < 26; k++) evt(k);
    idle(3);
    reg_wr(3'd0, EN | GIE | (4 << 1) | OVFEN | WBEN);
    for (int k = 30; k < 36; k++) evt(k);
    idle(4);
    reg_wr(3'd2, 32'h0000_FFFF);
    idle(2);
    // R6: disable mid-traffic
    evt(40);
    reg_wr(3'd0, EN | (4 << 1));
    idle(3);
    evt(41);
    // R2: 8-entry ring, no writeback, rptr updates interleaved
    reg_wr(3'd0, EN | GIE | (5 << 1) | OVFEN);
    for (int k = 50; k < 62; k++) begin
      evt_valid_i = 1;
      evt_src_i = 8'(k); evt_data_i = 28'(k * 999); evt_ring_i = 8'(k);
      evt_vmid_i = 8'(k); evt_pasid_i = 16'(k * 7);
      if (k % 3 == 0) begin
        reg_we_i = 1; reg_addr_i = 3'd2; reg_wdata_i = 32'(k * 16);
      end
      tick();
      reg_we_i = 0;
    end
    evt_valid_i = 0;
    idle(6);
    reg_wr(3'd0, 32'd0);
    idle(3);
    finish_run();
  end
endmodule